// File: doc/BRIEF.md
# Snooping MSI Cache-Line Coherence Controller

This block holds the coherence state of a small, fixed set of cache lines in a write-back, write-allocate cache. The cache runs a snooping MSI protocol on a totally ordered system bus. A core presents load, store and eviction requests with a valid/ready handshake. When the controller needs bus permission, it places a read-shared, read-exclusive or write-back request into a small outgoing queue. A queued request does not take effect when it is issued. The controller waits until it sees its own request appear in the ordered bus stream. While it waits, the line stays in a transient state that still behaves like the stable state the line came from.

The same ordered stream carries requests from other cores. The controller answers them by sending the line's data to the requester, to memory, or to both. A line can lose ownership while its own write-back is still queued. When that write-back is finally ordered, the controller tells memory that it no longer holds data by sending a data-less message. Data responses for pending misses arrive on a separate port. A response fills the line and completes the access that was waiting.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. No request is queued, and `core_hit`, `fill_done` and `snd_valid` are low.
- R2: Op codes are 0 load, 1 store, 2 evict and 3 no-op. Request kinds are 0 read-shared, 1 read-exclusive and 2 write-back. On an Invalid line, a load queues a read-shared request and a store queues a read-exclusive request. An eviction is accepted and queues nothing.
- R3: A line waiting for its own request to be ordered advances to the data-wait state only when a bus event with `bus_src` equal to `MY_ID`, the same line and the same kind arrives. A data response on a data-wait line pulses `fill_done` with the line one cycle later. The line then ends Shared after a load miss, or Modified after a store miss or upgrade.
- R4: In Shared, a load hits. A store queues read-exclusive and starts an upgrade. An eviction drops the line to Invalid and queues nothing. Another core's read-exclusive drops the line to Invalid and sends nothing.
- R5: During an upgrade, loads hit while stores and evictions stall. If another core's read-exclusive is ordered before the controller's own request, the line goes to the invalid-to-modified wait, and further loads stall.
- R6: In Modified, loads and stores hit. Another core's read-shared sends data to the requester and to memory, and the line becomes Shared. Another core's read-exclusive sends data to the requester only, and the line becomes Invalid. An eviction queues a write-back.
- R7: While a write-back is pending, loads and stores hit and evictions stall. The controller's own ordered write-back sends data to memory only and ends in Invalid. Another core's read-shared or read-exclusive is answered as in Modified, and the line then waits for its stale write-back.
- R8: In that stale-write-back wait, all core requests stall. When the write-back is ordered, the controller sends a data-less message to memory (`snd_nodata` and `snd_to_mem` high, `snd_to_req` low) and the line becomes Invalid.
- R9: Core requests other than op 3 stall while a line waits for its own read-shared or read-exclusive, or for its data. A bus event with no defined action for the line's state sends nothing and leaves the state unchanged.
- R10: Queued requests leave the queue in issue order. A request that would queue while the queue is full is refused with `core_ready` low.
- R11: A core request is refused in a cycle in which a bus event or data response targets the same line.
- R12: Op 3 is always accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_valid | input | 1 | Core request valid |
| core_ready | output | 1 | Core request accepted this cycle |
| core_op | input | 2 | 0 load, 1 store, 2 evict, 3 no-op |
| core_line | input | log2(NUM_LINES) | Line index of the core request |
| core_hit | output | 1 | The request accepted last cycle was a hit |
| fill_done | output | 1 | A data response completed a pending miss |
| fill_line | output | log2(NUM_LINES) | Line completed by `fill_done` |
| req_valid | output | 1 | Outgoing queue has a request at its head |
| req_ready | input | 1 | Bus side takes the head request |
| req_kind | output | 2 | Head request kind (0 read-shared, 1 read-exclusive, 2 write-back) |
| req_line | output | log2(NUM_LINES) | Head request line |
| bus_valid | input | 1 | Ordered bus event present |
| bus_kind | input | 2 | Kind of the ordered event (3 has no action) |
| bus_src | input | ID_W | Requester ID of the ordered event |
| bus_line | input | log2(NUM_LINES) | Line of the ordered event |
| rsp_valid | input | 1 | Data response present |
| rsp_line | input | log2(NUM_LINES) | Line the data response belongs to |
| snd_valid | output | 1 | Outgoing coherence message present |
| snd_to_req | output | 1 | Message carries data to the requesting core |
| snd_to_mem | output | 1 | Message goes to memory |
| snd_nodata | output | 1 | Memory message carries no data |
| snd_dest | output | ID_W | Requester ID the message answers |
| snd_line | output | log2(NUM_LINES) | Line of the message |

## Verification
The assertions assume the environment keeps to the protocol. Other cores' events never target a line that is waiting for its data, because the bus stalls any second transaction on a line until the first one completes. A data response arrives only for a line that is waiting for data. The controller's own ordered events match the head of its queue. Random stimulus keeps within these limits by drawing each event from a reference map of line states: responses go only to data-wait lines, foreign events skip them, and own events replay the modelled queue head.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [3:0] {
    ST_I, ST_IS_AD, ST_IS_D, ST_IM_AD, ST_IM_D,
    ST_S, ST_SM_AD, ST_SM_D, ST_M, ST_MI_A, ST_II_A
  } line_st_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2, OP_NONE = 2'd3
  } core_op_e;

  typedef enum logic [1:0] {
    RQ_GETS = 2'd0, RQ_GETM = 2'd1, RQ_PUTM = 2'd2, RQ_RSVD = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic      stall;
    logic      issue;
    req_kind_e kind;
    logic      hit;
    line_st_e  nxt;
  } core_act_t;

  typedef struct packed {
    line_st_e nxt;
    logic     to_req;
    logic     to_mem;
    logic     nodata;
  } snoop_act_t;

  // Reaction of a line to a core request.
  function automatic core_act_t core_step(line_st_e st, core_op_e op);
    core_act_t a;
    a.stall = 1'b0;
    a.issue = 1'b0;
    a.kind  = RQ_GETS;
    a.hit   = 1'b0;
    a.nxt   = st;
    if (op != OP_NONE) begin
      case (st)
        ST_I: begin
          if (op == OP_LOAD) begin
            a.issue = 1'b1; a.kind = RQ_GETS; a.nxt = ST_IS_AD;
          end else if (op == OP_STORE) begin
            a.issue = 1'b1; a.kind = RQ_GETM; a.nxt = ST_IM_AD;
          end
        end
        ST_S: begin
          if (op == OP_LOAD) a.hit = 1'b1;
          else if (op == OP_STORE) begin
            a.issue = 1'b1; a.kind = RQ_GETM; a.nxt = ST_SM_AD;
          end else a.nxt = ST_I;
        end
        ST_SM_AD, ST_SM_D: begin
          if (op == OP_LOAD) a.hit = 1'b1;
          else a.stall = 1'b1;
        end
        ST_M: begin
          if (op == OP_EVICT) begin
            a.issue = 1'b1; a.kind = RQ_PUTM; a.nxt = ST_MI_A;
          end else a.hit = 1'b1;
        end
        ST_MI_A: begin
          if (op == OP_EVICT) a.stall = 1'b1;
          else a.hit = 1'b1;
        end
        default: a.stall = 1'b1;
      endcase
    end
    return a;
  endfunction

  // Reaction of a line to an ordered bus event.
  function automatic snoop_act_t bus_step(line_st_e st, logic own, req_kind_e kind);
    snoop_act_t s;
    s.nxt    = st;
    s.to_req = 1'b0;
    s.to_mem = 1'b0;
    s.nodata = 1'b0;
    if (own) begin
      case (st)
        ST_IS_AD: if (kind == RQ_GETS) s.nxt = ST_IS_D;
        ST_IM_AD: if (kind == RQ_GETM) s.nxt = ST_IM_D;
        ST_SM_AD: if (kind == RQ_GETM) s.nxt = ST_SM_D;
        ST_MI_A: if (kind == RQ_PUTM) begin
          s.to_mem = 1'b1; s.nxt = ST_I;
        end
        ST_II_A: if (kind == RQ_PUTM) begin
          s.to_mem = 1'b1; s.nodata = 1'b1; s.nxt = ST_I;
        end
        default: ;
      endcase
    end else begin
      case (st)
        ST_S:     if (kind == RQ_GETM) s.nxt = ST_I;
        ST_SM_AD: if (kind == RQ_GETM) s.nxt = ST_IM_AD;
        ST_M, ST_MI_A: begin
          if (kind == RQ_GETS) begin
            s.to_req = 1'b1; s.to_mem = 1'b1;
            s.nxt = (st == ST_M) ? ST_S : ST_II_A;
          end else if (kind == RQ_GETM) begin
            s.to_req = 1'b1;
            s.nxt = (st == ST_M) ? ST_I : ST_II_A;
          end
        end
        default: ;
      endcase
    end
    return s;
  endfunction

  function automatic logic is_fill(line_st_e st);
    return (st == ST_IS_D) || (st == ST_IM_D) || (st == ST_SM_D);
  endfunction

  function automatic line_st_e fill_step(line_st_e st);
    case (st)
      ST_IS_D:          return ST_S;
      ST_IM_D, ST_SM_D: return ST_M;
      default:          return st;
    endcase
  endfunction

endpackage

// File: rtl/msi_req_fifo.sv
module msi_req_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/msi_line_fsm.sv
module msi_line_fsm
  import msi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     core_fire,
  input  line_st_e core_nxt,
  input  logic     bus_fire,
  input  line_st_e bus_nxt,
  input  logic     rsp_fire,
  input  line_st_e rsp_nxt,
  output line_st_e st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st <= ST_I;
    else if (rsp_fire)  st <= rsp_nxt;
    else if (bus_fire)  st <= bus_nxt;
    else if (core_fire) st <= core_nxt;
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int          NUM_LINES  = 4,
  parameter int          FIFO_DEPTH = 2,
  parameter int          ID_W       = 3,
  parameter int unsigned MY_ID      = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         core_valid,
  output logic                         core_ready,
  input  logic [1:0]                   core_op,
  input  logic [$clog2(NUM_LINES)-1:0] core_line,
  output logic                         core_hit,
  output logic                         fill_done,
  output logic [$clog2(NUM_LINES)-1:0] fill_line,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [1:0]                   req_kind,
  output logic [$clog2(NUM_LINES)-1:0] req_line,
  input  logic                         bus_valid,
  input  logic [1:0]                   bus_kind,
  input  logic [ID_W-1:0]              bus_src,
  input  logic [$clog2(NUM_LINES)-1:0] bus_line,
  input  logic                         rsp_valid,
  input  logic [$clog2(NUM_LINES)-1:0] rsp_line,
  output logic                         snd_valid,
  output logic                         snd_to_req,
  output logic                         snd_to_mem,
  output logic                         snd_nodata,
  output logic [ID_W-1:0]              snd_dest,
  output logic [$clog2(NUM_LINES)-1:0] snd_line
);
  localparam int LW = $clog2(NUM_LINES);
  localparam int QW = 2 + LW;

  line_st_e   line_st [NUM_LINES];
  line_st_e   sel_st, bus_st, rsp_st;
  core_act_t  cact;
  snoop_act_t sact;
  logic       bus_own, core_fire, fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic       bus_same, rsp_same;
  logic [QW-1:0] fifo_dout;
  logic [4*NUM_LINES-1:0] st_flat;

  always_comb begin
    sel_st   = line_st[core_line];
    bus_st   = line_st[bus_line];
    rsp_st   = line_st[rsp_line];
    bus_own  = (bus_src == ID_W'(MY_ID));
    cact     = core_step(sel_st, core_op_e'(core_op));
    sact     = bus_step(bus_st, bus_own, req_kind_e'(bus_kind));
    bus_same = bus_valid && (bus_line == core_line);
    rsp_same = rsp_valid && (rsp_line == core_line);
    core_ready = !cact.stall && !(cact.issue && fifo_full) && !bus_same && !rsp_same;
    core_fire  = core_valid && core_ready;
    fifo_push  = core_fire && cact.issue;
    for (int i = 0; i < NUM_LINES; i++) st_flat[i*4 +: 4] = line_st[i];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    msi_line_fsm u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_fire (core_fire && (core_line == LW'(g))),
      .core_nxt  (cact.nxt),
      .bus_fire  (bus_valid && (bus_line == LW'(g))),
      .bus_nxt   (sact.nxt),
      .rsp_fire  (rsp_valid && (rsp_line == LW'(g))),
      .rsp_nxt   (fill_step(rsp_st)),
      .st        (line_st[g])
    );
  end

  assign fifo_pop = req_valid && req_ready;

  msi_req_fifo #(.DEPTH(FIFO_DEPTH), .W(QW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   ({cact.kind, core_line}),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign req_valid = !fifo_empty;
  assign req_kind  = fifo_dout[QW-1 -: 2];
  assign req_line  = fifo_dout[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_hit   <= 1'b0;
      fill_done  <= 1'b0;
      fill_line  <= '0;
      snd_valid  <= 1'b0;
      snd_to_req <= 1'b0;
      snd_to_mem <= 1'b0;
      snd_nodata <= 1'b0;
      snd_dest   <= '0;
      snd_line   <= '0;
    end else begin
      core_hit   <= core_fire && cact.hit;
      fill_done  <= rsp_valid && is_fill(rsp_st);
      fill_line  <= rsp_line;
      snd_valid  <= bus_valid && (sact.to_req || sact.to_mem);
      snd_to_req <= bus_valid && sact.to_req;
      snd_to_mem <= bus_valid && sact.to_mem;
      snd_nodata <= bus_valid && sact.nodata;
      snd_dest   <= bus_src;
      snd_line   <= bus_line;
    end
  end
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int LW        = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   core_valid,
  input logic                   core_ready,
  input logic [1:0]             core_op,
  input logic [LW-1:0]          core_line,
  input line_st_e               sel_st,
  input logic                   bus_valid,
  input logic                   bus_own,
  input logic [1:0]             bus_kind,
  input logic [LW-1:0]          bus_line,
  input line_st_e               bus_st,
  input logic                   rsp_valid,
  input line_st_e               rsp_st,
  input logic                   fill_done,
  input logic                   snd_valid,
  input logic                   snd_to_req,
  input logic                   snd_to_mem,
  input logic                   snd_nodata,
  input logic                   fifo_full,
  input logic                   fifo_push,
  input logic [4*NUM_LINES-1:0] st_flat
);
  logic [LW-1:0] bl_q;
  always_ff @(posedge clk) bl_q <= bus_line;

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);

  p_stall_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_op != 2'd3 &&
     (sel_st == ST_IS_AD || sel_st == ST_IS_D || sel_st == ST_IM_AD ||
      sel_st == ST_IM_D || sel_st == ST_II_A)) |-> !core_ready);

  p_same_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && bus_valid && bus_line == core_line) |-> !core_ready);

  p_nodata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_own && bus_kind == 2'd2 && bus_st == ST_II_A) |=>
    (snd_valid && snd_nodata && snd_to_mem && !snd_to_req));

  p_demote_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_own && bus_kind == 2'd1 && bus_st == ST_SM_AD) |=>
    (st_flat[int'(bl_q)*4 +: 4] == 4'(ST_IM_AD)));

  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_st == ST_IS_D || rsp_st == ST_IM_D || rsp_st == ST_SM_D))
    |=> fill_done);

  p_owner_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_own && bus_kind == 2'd1 && bus_st == ST_M) |=>
    (snd_valid && snd_to_req && !snd_to_mem));

  p_nodata_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snd_nodata |-> (snd_to_mem && !snd_to_req));
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.NUM_LINES(NUM_LINES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
  .core_op(core_op), .core_line(core_line), .sel_st(sel_st),
  .bus_valid(bus_valid), .bus_own(bus_own), .bus_kind(bus_kind),
  .bus_line(bus_line), .bus_st(bus_st), .rsp_valid(rsp_valid), .rsp_st(rsp_st),
  .fill_done(fill_done), .snd_valid(snd_valid), .snd_to_req(snd_to_req),
  .snd_to_mem(snd_to_mem), .snd_nodata(snd_nodata), .fifo_full(fifo_full),
  .fifo_push(fifo_push), .st_flat(st_flat)
);

// File: tb/msi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_line_ctrl_tb_top;
  localparam int NL    = 4;
  localparam int DEPTH = 2;
  localparam int MYID  = 1;

  typedef enum int {B_I, B_ISAD, B_ISD, B_IMAD, B_IMD, B_S, B_SMAD, B_SMD,
                    B_M, B_MIA, B_IIA} bst_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_valid = 1'b0, core_ready;
  logic [1:0] core_op = 2'd0, core_line = 2'd0;
  logic core_hit, fill_done;
  logic [1:0] fill_line;
  logic req_valid, req_ready = 1'b0;
  logic [1:0] req_kind, req_line;
  logic bus_valid = 1'b0;
  logic [1:0] bus_kind = 2'd0, bus_line = 2'd0;
  logic [2:0] bus_src = 3'd0;
  logic rsp_valid = 1'b0;
  logic [1:0] rsp_line = 2'd0;
  logic snd_valid, snd_to_req, snd_to_mem, snd_nodata;
  logic [2:0] snd_dest;
  logic [1:0] snd_line;

  always #2 clk = ~clk;

  msi_line_ctrl #(.NUM_LINES(NL), .FIFO_DEPTH(DEPTH), .ID_W(3), .MY_ID(MYID)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
    .core_op(core_op), .core_line(core_line), .core_hit(core_hit),
    .fill_done(fill_done), .fill_line(fill_line), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_line(req_line),
    .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_src(bus_src),
    .bus_line(bus_line), .rsp_valid(rsp_valid), .rsp_line(rsp_line),
    .snd_valid(snd_valid), .snd_to_req(snd_to_req), .snd_to_mem(snd_to_mem),
    .snd_nodata(snd_nodata), .snd_dest(snd_dest), .snd_line(snd_line)
  );

  bst_t ref_st [NL];
  bit   other_m [NL];
  int   q_kind [8];
  int   q_line [8];
  int   q_cnt;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void ref_core(input bst_t st, input int op, output bit stall,
                                   output bit issue, output int kind, output bit hit,
                                   output bst_t nxt);
    stall = 0; issue = 0; kind = 0; hit = 0; nxt = st;
    if (op == 3) return;
    case (st)
      B_I:    if (op == 0) begin issue = 1; kind = 0; nxt = B_ISAD; end
              else if (op == 1) begin issue = 1; kind = 1; nxt = B_IMAD; end
      B_S:    if (op == 0) hit = 1;
              else if (op == 1) begin issue = 1; kind = 1; nxt = B_SMAD; end
              else nxt = B_I;
      B_SMAD, B_SMD: if (op == 0) hit = 1; else stall = 1;
      B_M:    if (op == 2) begin issue = 1; kind = 2; nxt = B_MIA; end else hit = 1;
      B_MIA:  if (op == 2) stall = 1; else hit = 1;
      default: stall = 1;
    endcase
  endfunction

  function automatic void ref_bus(input bst_t st, input bit own, input int kind,
                                  output bst_t nxt, output bit to_req,
                                  output bit to_mem, output bit nod);
    nxt = st; to_req = 0; to_mem = 0; nod = 0;
    if (own) begin
      if (st == B_ISAD && kind == 0) nxt = B_ISD;
      else if (st == B_IMAD && kind == 1) nxt = B_IMD;
      else if (st == B_SMAD && kind == 1) nxt = B_SMD;
      else if (st == B_MIA && kind == 2) begin to_mem = 1; nxt = B_I; end
      else if (st == B_IIA && kind == 2) begin to_mem = 1; nod = 1; nxt = B_I; end
    end else begin
      if (st == B_S && kind == 1) nxt = B_I;
      else if (st == B_SMAD && kind == 1) nxt = B_IMAD;
      else if ((st == B_M || st == B_MIA) && kind == 0) begin
        to_req = 1; to_mem = 1; nxt = (st == B_M) ? B_S : B_IIA;
      end else if ((st == B_M || st == B_MIA) && kind == 1) begin
        to_req = 1; nxt = (st == B_M) ? B_I : B_IIA;
      end
    end
  endfunction

  function automatic bit waits_data(bst_t st);
    return st == B_ISD || st == B_IMD || st == B_SMD;
  endfunction

  // One clock of stimulus; b_mode 0 none, 1 own (queue head), 2 other core.
  task automatic cyc(string tag, bit c_en, int c_line, int c_op, int b_mode,
                     int b_line, int b_kind, bit r_en, int r_line);
    bit stall, issue, hit, e_ready, fire, e_to_req, e_to_mem, e_nod, e_fill;
    int kind, src;
    bst_t c_nxt, b_nxt;
    if (b_mode == 1) begin
      if (q_cnt == 0) b_mode = 0;
      else begin b_line = q_line[0]; b_kind = q_kind[0]; end
    end
    src = (b_mode == 1) ? MYID : 2 + int'($urandom % 5);
    ref_core(ref_st[c_line], c_op, stall, issue, kind, hit, c_nxt);
    e_ready = !stall && !(issue && q_cnt >= DEPTH) &&
              !(b_mode != 0 && b_line == c_line) && !(r_en && r_line == c_line);
    fire = c_en && e_ready;
    e_to_req = 0; e_to_mem = 0; e_nod = 0; b_nxt = B_I;
    if (b_mode != 0)
      ref_bus(ref_st[b_line], b_mode == 1, b_kind, b_nxt, e_to_req, e_to_mem, e_nod);
    e_fill = r_en && waits_data(ref_st[r_line]);

    core_valid = c_en; core_line = 2'(c_line); core_op = 2'(c_op);
    bus_valid = (b_mode != 0); bus_line = 2'(b_line); bus_kind = 2'(b_kind);
    bus_src = 3'(src); req_ready = (b_mode == 1);
    rsp_valid = r_en; rsp_line = 2'(r_line);
    #1;
    if (c_en) chk(tag, "core_ready", int'(core_ready), int'(e_ready));
    if (b_mode == 1) begin
      chk("R10", "head kind", int'(req_kind), b_kind);
      chk("R10", "head line", int'(req_line), b_line);
    end
    @(posedge clk);
    @(negedge clk);
    core_valid = 0; bus_valid = 0; rsp_valid = 0; req_ready = 0;
    chk(tag, "core_hit", int'(core_hit), int'(fire && hit));
    chk(tag, "fill_done", int'(fill_done), int'(e_fill));
    if (e_fill) chk(tag, "fill_line", int'(fill_line), r_line);
    chk(tag, "snd_valid", int'(snd_valid), int'(e_to_req || e_to_mem));
    if (e_to_req || e_to_mem) begin
      chk(tag, "snd_to_req", int'(snd_to_req), int'(e_to_req));
      chk(tag, "snd_to_mem", int'(snd_to_mem), int'(e_to_mem));
      chk(tag, "snd_nodata", int'(snd_nodata), int'(e_nod));
      chk(tag, "snd_dest", int'(snd_dest), src);
      chk(tag, "snd_line", int'(snd_line), b_line);
    end
    // model update
    if (r_en && e_fill)
      ref_st[r_line] = (ref_st[r_line] == B_ISD) ? B_S : B_M;
    if (b_mode != 0) begin
      ref_st[b_line] = b_nxt;
      if (b_mode == 2 && b_kind == 1) other_m[b_line] = 1;
      if (b_mode == 2 && b_kind == 0) other_m[b_line] = 0;
      if (b_mode == 1 && b_kind == 1) other_m[b_line] = 0;
      if (b_mode == 1) begin
        for (int i = 0; i < 7; i++) begin q_kind[i] = q_kind[i+1]; q_line[i] = q_line[i+1]; end
        q_cnt--;
      end
    end
    if (fire) begin
      ref_st[c_line] = c_nxt;
      if (issue) begin q_kind[q_cnt] = kind; q_line[q_cnt] = c_line; q_cnt++; end
    end
    chk("R10", "req_valid", int'(req_valid), int'(q_cnt > 0));
    if (q_cnt > 0) begin
      chk("R10", "req_kind", int'(req_kind), q_kind[0]);
      chk("R10", "req_line", int'(req_line), q_line[0]);
    end
    for (int l = 0; l < NL; l++)
      if (ref_st[l] == B_M && other_m[l]) chk("R6", "single owner", 1, 0);
  endtask

  task automatic core(string t, int l, int op);   cyc(t, 1, l, op, 0, 0, 0, 0, 0); endtask
  task automatic own(string t);                   cyc(t, 0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic other(string t, int l, int k);   cyc(t, 0, 0, 0, 2, l, k, 0, 0); endtask
  task automatic rsp(string t, int l);            cyc(t, 0, 0, 0, 0, 0, 0, 1, l); endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < NL; l++) begin ref_st[l] = B_I; other_m[l] = 0; end
    q_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "req_valid", int'(req_valid), 0);
    chk("R1", "core_hit", int'(core_hit), 0);
    chk("R1", "fill_done", int'(fill_done), 0);
    chk("R1", "snd_valid", int'(snd_valid), 0);
    @(negedge clk);

    core("R2", 0, 0);            // GetS queued
    core("R2", 1, 1);            // GetM queued
    core("R10", 2, 1);           // queue full: refused
    core("R2", 3, 2);            // evict in I, nothing queued
    own("R3");                   // GetS L0 ordered
    core("R9", 0, 0);            // waiting data: stall
    rsp("R3", 0);                // L0 -> S
    core("R4", 0, 0);            // hit
    other("R4", 0, 1);           // S -> I silently
    core("R4", 0, 0);            // misses again
    own("R3");                   // GetM L1 ordered
    own("R3");                   // GetS L0 ordered
    rsp("R3", 1);                // L1 -> M
    rsp("R3", 0);                // L0 -> S
    other("R6", 1, 0);           // M: data to req+mem, -> S
    core("R4", 1, 1);            // upgrade
    core("R5", 1, 0);            // load hits during upgrade
    core("R5", 1, 2);            // evict stalls
    other("R5", 1, 1);           // demoted to IM_AD
    core("R5", 1, 0);            // load now stalls
    own("R3");
    rsp("R3", 1);                // L1 -> M
    core("R6", 1, 1);            // store hit
    core("R6", 1, 2);            // PutM queued
    core("R7", 1, 0);            // hit while write-back pending
    core("R7", 1, 2);            // second evict stalls
    own("R7");                   // data to memory, -> I
    core("R4", 0, 1);            // L0 upgrade
    own("R5");
    core("R5", 0, 0);            // load hit in SM_D
    rsp("R3", 0);                // -> M
    core("R6", 0, 2);            // PutM queued
    other("R7", 0, 0);           // answered, -> II_A
    core("R8", 0, 0);            // stall
    own("R8");                   // NoData
    core("R12", 2, 3);           // no-op accepted
    core("R12", 2, 0);           // still I: misses
    cyc("R11", 1, 3, 0, 2, 3, 0, 0, 0);  // same-line bus event refuses core
    other("R9", 1, 2);           // no action
    other("R9", 1, 3);           // reserved kind, no action

    for (int n = 0; n < 6000; n++) begin
      int r, l, k, d;
      r = int'($urandom % 10);
      l = int'($urandom % NL);
      if (r < 4) core("R9", l, int'($urandom % 4));
      else if (r < 6) own("R3");
      else if (r < 8) begin
        k = int'($urandom % 4);
        if (!waits_data(ref_st[l])) other("R6", l, k);
        else core("R9", l, 0);
      end else if (r == 8) begin
        d = -1;
        for (int j = 0; j < NL; j++) if (d < 0 && waits_data(ref_st[j])) d = j;
        if (d >= 0) rsp("R3", d); else core("R12", l, 3);
      end else begin
        if (!waits_data(ref_st[l])) cyc("R11", 1, l, int'($urandom % 3), 2, l, int'($urandom % 2), 0, 0);
        else cyc("R11", 1, l, 0, 0, 0, 0, 1, l);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule